// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address sequence of one read or write burst for a synchronous DRAM controller. A column command supplies a starting column, a burst length code and an ordering choice. From the next clock onward, the generator emits one column per cycle, with a valid flag and a flag on the final beat. Two orderings are supported. Sequential ordering wraps inside the burst-aligned block, or across the whole page. Interleaved ordering flips the low address bits by the beat index.

A burst in progress can end early in two ways. A stop strobe ends it. A fresh command, given on the start strobe or the interrupt strobe, replaces it on any cycle and restarts from that command's own column. Commands may arrive on consecutive clocks.

The control sits in a three-state machine:
- `ST_IDLE` means no burst is running.
- `ST_RUN` means a burst of fixed length is running.
- `ST_PAGE` means an open-ended full-page burst is running.

The machine has these transitions:
- LAUNCH moves from any state to `ST_RUN` or `ST_PAGE`.
- STOP moves from `ST_RUN` or `ST_PAGE` to `ST_IDLE`.
- DONE moves from `ST_RUN` to `ST_IDLE` after the last beat.
- STEP stays in `ST_RUN` or `ST_PAGE` and advances the beat.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `valid_o` and `last_o` are 0 and `col_o` is 0.
- R2: A command sampled on a clock edge puts beat 0 on `col_o`, equal to the command's start column, in the cycle after that edge. Each later cycle advances one beat.
- R3: Length codes are 0 for 1 beat, 1 for 2, 2 for 4, 3 for 8 and 7 for full page. In sequential ordering (`order_i`=0) with length BL, beat i carries the start column's low log2(BL) bits plus i, taken modulo BL. The upper bits stay fixed.
- R4: In interleaved ordering (`order_i`=1), beat i carries the start column with its low log2(BL) bits XORed with i.
- R5: `last_o` is 1 only on beat BL-1 of a fixed-length burst. `valid_o` is 0 in the next cycle unless a new command was sampled.
- R6: Length code 0 and the spare codes 4, 5 and 6 give a single beat, which has `last_o`=1.
- R7: Full page in sequential ordering increments all 9 bits modulo 512. It never raises `last_o` and runs until stopped or replaced.
- R8: Full-page length combined with interleaved ordering runs as length 8.
- R9: A stop sampled during a burst makes `valid_o` 0 in the next cycle. A stop sampled while idle changes nothing.
- R10: A command sampled during a burst restarts it at the command's column. When `intr_i` and `start_i` are both high, `intr_i` and `intr_col_i` win. A command sampled together with a stop wins over the stop.
- R11: Commands on consecutive clocks each produce their own beat 0 in the cycle after each one.
- R12: `col_o` is 0 whenever `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Column command strobe |
| start_col_i | input | 9 | Start column for `start_i` |
| intr_i | input | 1 | Replacing command strobe |
| intr_col_i | input | 9 | Start column for `intr_i` |
| len_code_i | input | 3 | Burst length code, sampled with a command |
| order_i | input | 1 | 0 sequential, 1 interleaved, sampled with a command |
| stop_i | input | 1 | Burst stop strobe |
| col_o | output | 9 | Current column |
| valid_o | output | 1 | A beat is present on `col_o` |
| last_o | output | 1 | Current beat is the final one |

## Verification
Every result is registered once, so each output is due exactly one clock after the edge that sampled the strobe causing it:
- beat 0 follows a command by one cycle;
- each later beat follows its predecessor by one cycle;
- `valid_o` falls one cycle after a stop or after the last beat.

The bench drives strobes on the falling edge. The following rising edge samples them, and the bench compares the outputs at the next falling edge. A command therefore shows its effect at the first falling edge after it is driven. Each scenario walks the beats one falling edge at a time against a reference sequence computed from the requirements.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_PAGE = 2'd2
    } bcg_state_e;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } bcg_order_e;

    localparam logic [2:0] LEN_1    = 3'd0;
    localparam logic [2:0] LEN_2    = 3'd1;
    localparam logic [2:0] LEN_4    = 3'd2;
    localparam logic [2:0] LEN_8    = 3'd3;
    localparam logic [2:0] LEN_PAGE = 3'd7;

endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [2:0]       code_i,
    input  logic             order_i,
    output logic [COL_W-1:0] mask_o,
    output logic             full_o
);
    localparam logic [COL_W-1:0] MASK_ALL = {COL_W{1'b1}};

    always_comb begin
        full_o = 1'b0;
        unique case (code_i)
            LEN_2:    mask_o = COL_W'(1);
            LEN_4:    mask_o = COL_W'(3);
            LEN_8:    mask_o = COL_W'(7);
            LEN_PAGE: begin
                if (order_i == ORD_ILV) begin
                    mask_o = COL_W'(7);
                end else begin
                    mask_o = MASK_ALL;
                    full_o = 1'b1;
                end
            end
            default:  mask_o = '0;
        endcase
    end

    always_comb begin
        assert (!full_o || order_i == ORD_SEQ)
            else $error("AST_PAGE_SEQ_ONLY"); // R8
    end
endmodule

// File: rtl/bcg_addr_calc.sv
module bcg_addr_calc #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] low_seq;
    logic [COL_W-1:0] low_ilv;

    always_comb begin
        low_seq = COL_W'(base_i + beat_i);
        low_ilv = base_i ^ beat_i;
        col_o   = (base_i & ~mask_i) | ((ilv_i ? low_ilv : low_seq) & mask_i);
    end
endmodule

// File: rtl/bcg_ctrl.sv
module bcg_ctrl
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    input  logic [COL_W-1:0] launch_col_i,
    input  logic [COL_W-1:0] dec_mask_i,
    input  logic             dec_full_i,
    input  logic             dec_ilv_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] calc_col_i,
    output logic [COL_W-1:0] base_n_o,
    output logic [COL_W-1:0] beat_n_o,
    output logic [COL_W-1:0] mask_n_o,
    output logic             ilv_n_o,
    output bcg_state_e       state_o,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);
    bcg_state_e       state_q, state_n;
    logic [COL_W-1:0] base_q, beat_q, mask_q, col_q;
    logic             ilv_q, last_q, last_n;

    // next-state and datapath-next logic
    always_comb begin
        state_n  = state_q;
        base_n_o = base_q;
        beat_n_o = beat_q;
        mask_n_o = mask_q;
        ilv_n_o  = ilv_q;
        if (launch_i) begin
            state_n  = dec_full_i ? ST_PAGE : ST_RUN;
            base_n_o = launch_col_i;
            beat_n_o = '0;
            mask_n_o = dec_mask_i;
            ilv_n_o  = dec_ilv_i;
        end else begin
            unique case (state_q)
                ST_IDLE: state_n = ST_IDLE;
                ST_RUN: begin
                    if (stop_i || last_q) state_n = ST_IDLE;
                    else beat_n_o = beat_q + 1'b1;
                end
                ST_PAGE: begin
                    if (stop_i) state_n = ST_IDLE;
                    else beat_n_o = beat_q + 1'b1;
                end
                default: state_n = ST_IDLE;
            endcase
        end
        last_n = (state_n == ST_RUN) && (beat_n_o == mask_n_o);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            beat_q  <= '0;
            mask_q  <= '0;
            ilv_q   <= 1'b0;
            col_q   <= '0;
            last_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            base_q  <= base_n_o;
            beat_q  <= beat_n_o;
            mask_q  <= mask_n_o;
            ilv_q   <= ilv_n_o;
            col_q   <= calc_col_i;
            last_q  <= last_n;
        end
    end

    // outputs
    always_comb begin
        state_o = state_q;
        valid_o = (state_q != ST_IDLE);
        col_o   = valid_o ? col_q : '0;
        last_o  = valid_o && last_q;
    end

    AST_RUN_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (beat_q <= mask_q)); // R5
    AST_RUN_ENDS_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && last_q && !launch_i) |=> (state_q == ST_IDLE)); // R5
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             intr_i,
    input  logic [COL_W-1:0] intr_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             order_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);
    logic             launch;
    logic [COL_W-1:0] launch_col;
    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic [COL_W-1:0] base_n, beat_n, mask_n, calc_col;
    logic             ilv_n;
    bcg_state_e       state;

    assign launch     = start_i | intr_i;
    assign launch_col = intr_i ? intr_col_i : start_col_i;

    bcg_len_decode #(.COL_W(COL_W)) u_dec (
        .code_i  (len_code_i),
        .order_i (order_i),
        .mask_o  (dec_mask),
        .full_o  (dec_full)
    );

    bcg_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch_i     (launch),
        .launch_col_i (launch_col),
        .dec_mask_i   (dec_mask),
        .dec_full_i   (dec_full),
        .dec_ilv_i    (order_i),
        .stop_i       (stop_i),
        .calc_col_i   (calc_col),
        .base_n_o     (base_n),
        .beat_n_o     (beat_n),
        .mask_n_o     (mask_n),
        .ilv_n_o      (ilv_n),
        .state_o      (state),
        .col_o        (col_o),
        .valid_o      (valid_o),
        .last_o       (last_o)
    );

    bcg_addr_calc #(.COL_W(COL_W)) u_calc (
        .base_i (base_n),
        .beat_i (beat_n),
        .mask_i (mask_n),
        .ilv_i  (ilv_n),
        .col_o  (calc_col)
    );

    AST_LAUNCH_GIVES_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> valid_o); // R2
    AST_LAUNCH_COL: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (col_o == $past(launch_col))); // R10
    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !launch) |=> !valid_o); // R9
    AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAGE) |-> !last_o); // R7
    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAGE && !launch && !stop_i) |=>
        (col_o == COL_W'($past(col_o) + 1'b1))); // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (col_o == '0 && !last_o)); // R12
endmodule

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i, intr_i, order_i, stop_i;
    logic [8:0] start_col_i, intr_col_i;
    logic [2:0] len_code_i;
    logic [8:0] col_o;
    logic       valid_o, last_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    burst_col_gen u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .intr_i(intr_i), .intr_col_i(intr_col_i), .len_code_i(len_code_i),
        .order_i(order_i), .stop_i(stop_i), .col_o(col_o), .valid_o(valid_o),
        .last_o(last_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_len(input int code, input int ilv);
        case (code)
            1: return 2;
            2: return 4;
            3: return 8;
            7: return ilv ? 8 : 512;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col(input int base, input int i, input int len, input int ilv);
        int m = len - 1;
        if (ilv) return (base & ~m & 511) | ((base ^ i) & m);
        return (base & ~m & 511) | ((base + i) & m);
    endfunction

    task automatic idle_inputs();
        start_i = 0; intr_i = 0; stop_i = 0;
        start_col_i = 0; intr_col_i = 0; len_code_i = 0; order_i = 0;
    endtask

    // drive a command at a falling edge, return at the next falling edge (beat 0 visible)
    task automatic launch(input int col, input int code, input int ilv);
        start_i = 1; start_col_i = 9'(col); len_code_i = 3'(code); order_i = ilv[0];
        @(negedge clk);
        start_i = 0;
    endtask

    task automatic walk(input int base, input int code, input int ilv, input string req);
        int len = exp_len(code, ilv);
        for (int i = 0; i < len; i++) begin
            chk(valid_o, req, valid_o, 1);
            chk(col_o == 9'(exp_col(base, i, len, ilv)), req, col_o, exp_col(base, i, len, ilv));
            chk(last_o == (i == len - 1), {req, " R5 last"}, last_o, i == len - 1);
            @(negedge clk);
        end
        chk(!valid_o, {req, " R5 end"}, valid_o, 0);
        chk(col_o == 0, {req, " R12"}, col_o, 0);
    endtask

    task automatic t_reset();
        chk(!valid_o, "R1 valid", valid_o, 0);
        chk(!last_o, "R1 last", last_o, 0);
        chk(col_o == 0, "R1 col", col_o, 0);
    endtask

    task automatic t_sequential();
        launch(13, 3, 0); walk(13, 3, 0, "R3 seq8");   // 13,14,15,8..12
        launch(6, 2, 0);  walk(6, 2, 0, "R3 seq4");    // 6,7,4,5
        launch(301, 1, 0); walk(301, 1, 0, "R2 seq2");
    endtask

    task automatic t_interleave();
        launch(13, 3, 1); walk(13, 3, 1, "R4 ilv8");
        launch(2, 2, 1);  walk(2, 2, 1, "R4 ilv4");
    endtask

    task automatic t_single();
        launch(77, 0, 0); walk(77, 0, 0, "R6 code0");
        launch(88, 5, 1); walk(88, 5, 1, "R6 code5");
        launch(99, 4, 0); walk(99, 4, 0, "R6 code4");
    endtask

    task automatic t_page();
        bit ok = 1;
        launch(505, 7, 0);
        for (int i = 0; i < 520; i++) begin
            if (col_o != 9'((505 + i) % 512) || !valid_o || last_o) begin
                ok = 0;
                chk(0, "R7 page beat", col_o, (505 + i) % 512);
            end
            @(negedge clk);
        end
        chk(ok, "R7 page wrap", ok, 1);
        chk(valid_o, "R7 still running", valid_o, 1);
        stop_i = 1; @(negedge clk); stop_i = 0;
        chk(!valid_o, "R9 stop page", valid_o, 0);
    endtask

    task automatic t_page_ilv();
        launch(21, 7, 1); walk(21, 7, 1, "R8 ilv page as 8");
    endtask

    task automatic t_stop();
        launch(40, 3, 0);
        chk(col_o == 40, "R9 beat0", col_o, 40);
        @(negedge clk);
        stop_i = 1; @(negedge clk); stop_i = 0;
        chk(!valid_o, "R9 stop", valid_o, 0);
        stop_i = 1; @(negedge clk); stop_i = 0;
        chk(!valid_o && col_o == 0, "R9 idle stop", valid_o, 0);
        launch(50, 1, 0); walk(50, 1, 0, "R9 after idle stop");
    endtask

    task automatic t_interrupt();
        launch(5, 3, 0);
        @(negedge clk);
        chk(col_o == 6, "R10 pre", col_o, 6);
        intr_i = 1; intr_col_i = 100; start_i = 1; start_col_i = 200;
        len_code_i = 2; order_i = 0;
        @(negedge clk);
        intr_i = 0; start_i = 0;
        walk(100, 2, 0, "R10 intr wins");
        launch(60, 3, 0);
        start_i = 1; stop_i = 1; start_col_i = 33; len_code_i = 1;
        @(negedge clk);
        start_i = 0; stop_i = 0;
        walk(33, 1, 0, "R10 cmd beats stop");
    endtask

    task automatic t_back_to_back();
        start_i = 1; len_code_i = 2; order_i = 0; start_col_i = 10;
        @(negedge clk);
        chk(col_o == 10 && !last_o, "R11 first", col_o, 10);
        start_col_i = 20;
        @(negedge clk);
        chk(col_o == 20, "R11 second", col_o, 20);
        start_col_i = 30;
        @(negedge clk);
        start_i = 0;
        walk(30, 2, 0, "R11 third");
    endtask

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_sequential();
        t_interleave();
        t_single();
        t_page();
        t_page_ilv();
        t_stop();
        t_interrupt();
        t_back_to_back();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule